// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table that is held in external memory, and the page size is 4 KB. The virtual address is cut into three fields, counted from the top:
- a 10-bit first-level index;
- a 10-bit second-level index;
- a 12-bit byte offset.

The caller supplies the page number of the first-level table along with each request. The block then reads one entry from the first-level table. That entry names the page that holds a second-level table. The block reads one entry from that table. The second entry names the physical frame, and the frame is joined with the offset to form the result.

Each table entry is 32 bits wide. Bits 31:12 carry a page number and bit 0 is the valid flag. Bits 11:1 carry no meaning for this block. If the valid flag is clear at either level, the walk stops and reports a fault that names the level. Only one memory read is in flight at a time. A new request is taken only when the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: While reset is high, and in the cycle after it, `req_ready` is 1, and `mem_rd_en` and `resp_valid` are 0.
- R2: A request is taken on a clock edge where both `req_valid` and `req_ready` are 1. In the next cycle `mem_rd_en` is 1 and `mem_rd_addr` equals `req_root_page`*4096 + (vaddr bits 31:22)*4.
- R3: If the first-level entry returned has bit 0 set, the second read is issued in the cycle after that data arrives. Its address is (entry bits 31:12)*4096 + (vaddr bits 21:12)*4.
- R4: If the first-level entry has bit 0 clear, the walk ends with `resp_fault` = 2'b01, and no second read is issued.
- R5: If the second-level entry has bit 0 clear, the walk ends with `resp_fault` = 2'b10.
- R6: On success, `resp_fault` = 2'b00 and `resp_paddr` = {second-level entry bits 31:12, vaddr bits 11:0}. `resp_valid` goes high in the cycle after the final read data arrives.
- R7: `mem_rd_en` is a one-cycle pulse. No new read is issued while an earlier read still waits for `mem_rd_valid`.
- R8: `resp_valid` is a one-cycle pulse. `req_ready` returns to 1 in the cycle after it. `resp_fault` never takes the value 2'b11.
- R9: From the cycle after a request is taken until the response, `req_ready` is 0. A request offered in that window is ignored and does not change the result.
- R10: A `mem_rd_valid` pulse that arrives while no read is outstanding is ignored: it produces no response and no memory read.
- R11: Entry bits 11:1 are ignored at both levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root_page | input | 20 | Page number of the first-level table |
| mem_rd_en | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Table entry read from memory |
| resp_valid | output | 1 | Result pulse |
| resp_paddr | output | 32 | Physical address (valid when fault is 00) |
| resp_fault | output | 2 | 00 none, 01 first-level invalid, 10 second-level invalid |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, 10-bit indices at both levels, a 12-bit offset and 32-bit entries. With these values the extreme indices 0 and 1023 at both levels can be reached, as can offsets 0x000 and 0xFFF. The memory model in the bench returns data after one, two or three cycles, which exercises the single-outstanding-read rule and the one-cycle response timing under different latencies. Faults at each level, entries with junk in bits 11:1, requests offered while the walker is busy, and stray read-data pulses while idle are each driven against a behavioural model of the walk.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_OUT = 3'd1,
    ST_RD_IN  = 3'd2,
    ST_DONE   = 3'd3,
    ST_FAULT  = 3'd4
  } walk_state_t;

  localparam logic [1:0] FLT_NONE  = 2'b00;
  localparam logic [1:0] FLT_OUTER = 2'b01;
  localparam logic [1:0] FLT_INNER = 2'b10;

endpackage

// File: rtl/pw_va_split.sv
module pw_va_split #(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic [VA_W-1:0]  va,
  output logic [IDX_W-1:0] outer_idx,
  output logic [IDX_W-1:0] inner_idx,
  output logic [OFF_W-1:0] offset
);
  localparam int INNER_LSB = OFF_W;
  localparam int OUTER_LSB = OFF_W + IDX_W;

  assign outer_idx = va[OUTER_LSB +: IDX_W];
  assign inner_idx = va[INNER_LSB +: IDX_W];
  assign offset    = va[OFF_W-1:0];
endmodule

// File: rtl/pw_pte_decode.sv
module pw_pte_decode #(
  parameter int PTE_W     = 32,
  parameter int PA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int VALID_BIT = 0,
  localparam int PN_W     = PA_W - OFF_W
) (
  input  logic [PTE_W-1:0] pte,
  output logic             pte_ok,
  output logic [PN_W-1:0]  pte_page
);
  logic unused_pte_bits;

  assign pte_ok          = pte[VALID_BIT];
  assign pte_page        = pte[PTE_W-1 -: PN_W];
  assign unused_pte_bits = ^pte;
endmodule

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
  parameter int PA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int ENT_SH = 2,
  localparam int PN_W  = PA_W - OFF_W
) (
  input  logic [PN_W-1:0]  tbl_page,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  addr
);
  logic [PA_W-1:0] tbl_base;
  logic [PA_W-1:0] idx_bytes;

  assign tbl_base  = {tbl_page, {OFF_W{1'b0}}};
  assign idx_bytes = PA_W'({idx, {ENT_SH{1'b0}}});
  assign addr      = tbl_base + idx_bytes;
endmodule

// File: rtl/pw_walk_fsm.sv
module pw_walk_fsm
  import pw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_fire,
  input  logic        rd_valid,
  input  logic        pte_ok,
  output walk_state_t st,
  output logic        issue_outer,
  output logic        issue_inner,
  output logic        fin_ok,
  output logic        flt_outer,
  output logic        flt_inner,
  output logic        to_idle
);
  walk_state_t nxt;

  always_comb begin
    nxt         = st;
    issue_outer = 1'b0;
    issue_inner = 1'b0;
    fin_ok      = 1'b0;
    flt_outer   = 1'b0;
    flt_inner   = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req_fire) begin
          nxt         = ST_RD_OUT;
          issue_outer = 1'b1;
        end
      end
      ST_RD_OUT: begin
        if (rd_valid) begin
          if (pte_ok) begin
            nxt         = ST_RD_IN;
            issue_inner = 1'b1;
          end else begin
            nxt       = ST_FAULT;
            flt_outer = 1'b1;
          end
        end
      end
      ST_RD_IN: begin
        if (rd_valid) begin
          if (pte_ok) begin
            nxt    = ST_DONE;
            fin_ok = 1'b1;
          end else begin
            nxt       = ST_FAULT;
            flt_inner = 1'b1;
          end
        end
      end
      ST_DONE:  nxt = ST_IDLE;
      ST_FAULT: nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign to_idle = (nxt == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int IDX_W     = 10,
  parameter int PTE_W     = 32,
  parameter int VALID_BIT = 0,
  localparam int PN_W     = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PN_W-1:0]  req_root_page,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [PTE_W-1:0] mem_rd_data,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [1:0]       resp_fault
);
  localparam int ENT_BYTES = PTE_W / 8;
  localparam int ENT_SH    = $clog2(ENT_BYTES);

  walk_state_t     st;
  logic            req_fire;
  logic            issue_outer, issue_inner, fin_ok, flt_outer, flt_inner, to_idle;
  logic [VA_W-1:0] va_q;

  logic [IDX_W-1:0] in_outer_idx, unused_in_inner;
  logic [OFF_W-1:0] unused_in_off;
  logic [IDX_W-1:0] unused_q_outer, q_inner_idx;
  logic [OFF_W-1:0] q_offset;

  logic            pte_ok;
  logic [PN_W-1:0] pte_page;

  logic [PN_W-1:0]  sel_page;
  logic [IDX_W-1:0] sel_idx;
  logic [PA_W-1:0]  entry_addr;

  assign req_fire = req_valid && req_ready;

  pw_va_split #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_split_req (
    .va(req_vaddr), .outer_idx(in_outer_idx),
    .inner_idx(unused_in_inner), .offset(unused_in_off)
  );

  pw_va_split #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_split_held (
    .va(va_q), .outer_idx(unused_q_outer),
    .inner_idx(q_inner_idx), .offset(q_offset)
  );

  pw_pte_decode #(.PTE_W(PTE_W), .PA_W(PA_W), .OFF_W(OFF_W), .VALID_BIT(VALID_BIT)) i_pte (
    .pte(mem_rd_data), .pte_ok(pte_ok), .pte_page(pte_page)
  );

  // One adder serves both levels; the level being issued picks its inputs.
  assign sel_page = issue_inner ? pte_page    : req_root_page;
  assign sel_idx  = issue_inner ? q_inner_idx : in_outer_idx;

  pw_entry_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_SH(ENT_SH)) i_addr (
    .tbl_page(sel_page), .idx(sel_idx), .addr(entry_addr)
  );

  pw_walk_fsm i_fsm (
    .clk(clk), .rst(rst), .req_fire(req_fire), .rd_valid(mem_rd_valid),
    .pte_ok(pte_ok), .st(st), .issue_outer(issue_outer), .issue_inner(issue_inner),
    .fin_ok(fin_ok), .flt_outer(flt_outer), .flt_inner(flt_inner), .to_idle(to_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready   <= 1'b1;
      va_q        <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      resp_valid  <= 1'b0;
      resp_paddr  <= '0;
      resp_fault  <= FLT_NONE;
    end else begin
      req_ready  <= to_idle;
      mem_rd_en  <= issue_outer || issue_inner;
      resp_valid <= fin_ok || flt_outer || flt_inner;
      if (issue_outer) va_q <= req_vaddr;
      if (issue_outer || issue_inner) mem_rd_addr <= entry_addr;
      if (fin_ok) begin
        resp_paddr <= {pte_page, q_offset};
        resp_fault <= FLT_NONE;
      end else if (flt_outer) begin
        resp_paddr <= '0;
        resp_fault <= FLT_OUTER;
      end else if (flt_inner) begin
        resp_paddr <= '0;
        resp_fault <= FLT_INNER;
      end
    end
  end
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int IDX_W     = 10,
  parameter int PTE_W     = 32,
  localparam int PN_W     = PA_W - OFF_W
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic [PN_W-1:0]  req_root_page,
  input logic             mem_rd_en,
  input logic [PA_W-1:0]  mem_rd_addr,
  input logic             mem_rd_valid,
  input logic [PTE_W-1:0] mem_rd_data,
  input logic             resp_valid,
  input logic [PA_W-1:0]  resp_paddr,
  input logic [1:0]       resp_fault
);
  localparam int ENT_BYTES = PTE_W / 8;

  logic            outst;
  logic            busy;
  logic [1:0]      nreads;
  logic [VA_W-1:0] va_seen;
  logic            unused_chk;

  assign unused_chk = ^mem_rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      outst   <= 1'b0;
      busy    <= 1'b0;
      nreads  <= '0;
      va_seen <= '0;
    end else begin
      if (mem_rd_en) outst <= 1'b1;
      else if (mem_rd_valid) outst <= 1'b0;
      if (req_valid && req_ready) begin
        busy    <= 1'b1;
        nreads  <= '0;
        va_seen <= req_vaddr;
      end else begin
        if (resp_valid) busy <= 1'b0;
        if (mem_rd_en && nreads != 2'd3) nreads <= nreads + 2'd1;
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (req_ready && !mem_rd_en && !resp_valid));

  a_r2_first_read: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_rd_en && mem_rd_addr ==
      ({$past(req_root_page), {OFF_W{1'b0}}} +
       PA_W'($past(req_vaddr[VA_W-1 -: IDX_W])) * ENT_BYTES)));

  a_r4_no_second_read: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault == 2'b01) |-> (nreads == 2'd1));

  a_r6_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault == 2'b00) |-> (resp_paddr[OFF_W-1:0] == va_seen[OFF_W-1:0] && nreads == 2'd2));

  a_r7_single_read: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && outst));

  a_r7_read_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  a_r8_resp_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> (!resp_valid && req_ready));

  a_r8_fault_code: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $onehot0(resp_fault));

  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);
endmodule

bind pt_walker pw_checker #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_W(PTE_W)
) i_pw_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .req_root_page(req_root_page), .mem_rd_en(mem_rd_en),
  .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
  .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [19:0] req_root_page = '0;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic [1:0]  resp_fault;

  pt_walker i_pt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root_page(req_root_page), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_data_cyc = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_addr_q [$];
  string       exp_tag_q  [$];

  int          lat = 1;
  bit          pend = 0;
  int          cnt = 0;
  logic [31:0] pend_addr = '0;
  bit          stray_req = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] rdm(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Memory model: answers each read after 'lat' cycles; checks every issued address.
  always @(negedge clk) begin
    if (rst) begin
      mem_rd_valid = 1'b0;
      pend = 0;
    end else begin
      mem_rd_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rd_valid  = 1'b1;
          mem_rd_data   = rdm(pend_addr);
          pend          = 0;
          last_data_cyc = cyc;
        end else cnt--;
      end else if (stray_req) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = 32'hFFFF_F001;
        stray_req    = 0;
      end
      if (mem_rd_en) begin
        if (pend) chk(0, "R7 read issued while one outstanding", mem_rd_addr, pend_addr);
        if (exp_addr_q.size() == 0) begin
          chk(0, "R7 unexpected read", mem_rd_addr, 32'h0);
        end else begin
          logic [31:0] ea;
          string       et;
          ea = exp_addr_q.pop_front();
          et = exp_tag_q.pop_front();
          chk(mem_rd_addr == ea, et, mem_rd_addr, ea);
        end
        pend      = 1;
        pend_addr = mem_rd_addr;
        cnt       = lat - 1;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [19:0] root, input int l,
                      input bit junk, input string tag);
    logic [31:0] a1, e1, a2, e2, xp;
    logic [1:0]  xf;
    int          t;
    a1 = {root, 12'h000} + {20'h0, va[31:22], 2'b00};
    e1 = rdm(a1);
    a2 = '0; e2 = '0; xp = '0;
    if (!e1[0]) xf = 2'b01;
    else begin
      a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      e2 = rdm(a2);
      if (!e2[0]) xf = 2'b10;
      else begin
        xf = 2'b00;
        xp = {e2[31:12], va[11:0]};
      end
    end
    lat = l;
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R8 ready before request"}, 32'(req_ready), 32'd1);
    exp_addr_q.push_back(a1); exp_tag_q.push_back({tag, " R2 first-level address"});
    if (e1[0]) begin
      exp_addr_q.push_back(a2); exp_tag_q.push_back({tag, " R3 second-level address"});
    end
    req_valid = 1'b1; req_vaddr = va; req_root_page = root;
    @(negedge clk);
    req_valid = 1'b0;
    if (junk) begin
      chk(req_ready == 1'b0, {tag, " R9 ready low while busy"}, 32'(req_ready), 32'd0);
      req_valid = 1'b1; req_vaddr = ~va; req_root_page = ~root;
      @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!resp_valid && t < 60) begin
      @(negedge clk);
      t++;
    end
    chk(resp_valid == 1'b1, {tag, " R8 response seen"}, 32'(resp_valid), 32'd1);
    chk(cyc == last_data_cyc + 1, {tag, " R6 response one cycle after data"}, cyc, last_data_cyc + 1);
    if (xf == 2'b01)      chk(resp_fault == xf, {tag, " R4 outer fault code"}, 32'(resp_fault), 32'(xf));
    else if (xf == 2'b10) chk(resp_fault == xf, {tag, " R5 inner fault code"}, 32'(resp_fault), 32'(xf));
    else begin
      chk(resp_fault == xf, {tag, " R6 no fault"}, 32'(resp_fault), 32'(xf));
      chk(resp_paddr == xp, {tag, " R6 physical address"}, resp_paddr, xp);
    end
    @(negedge clk);
    chk(resp_valid == 1'b0, {tag, " R8 response one cycle"}, 32'(resp_valid), 32'd0);
    chk(req_ready == 1'b1, {tag, " R8 ready after response"}, 32'(req_ready), 32'd1);
    chk(exp_addr_q.size() == 0, {tag, " R4 read count"}, exp_addr_q.size(), 32'd0);
  endtask

  initial begin
    // Tables: root page 0x00100
    mem[32'h0010_0000 + 5*4]    = 32'h0020_0001;
    mem[32'h0020_0000 + 7*4]    = 32'hABCD_E001;
    mem[32'h0020_0000 + 8*4]    = 32'h1234_5001;
    mem[32'h0020_0000 + 9*4]    = 32'h5555_5000;
    mem[32'h0010_0000 + 1023*4] = 32'h0030_0FFF;
    mem[32'h0030_0000 + 1023*4] = 32'h7777_7FFF;
    mem[32'h0010_0000]          = 32'h0040_0001;
    mem[32'h0040_0000]          = 32'h0000_0001;

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
    chk(mem_rd_en == 1'b0, "R1 no read in reset", 32'(mem_rd_en), 32'd0);
    chk(resp_valid == 1'b0, "R1 no response in reset", 32'(resp_valid), 32'd0);
    rst = 1'b0;

    walk({10'd5, 10'd7, 12'h123}, 20'h00100, 1, 0, "basic");
    walk({10'd5, 10'd8, 12'hFFF}, 20'h00100, 3, 0, "slow memory");
    walk({10'd6, 10'd7, 12'h001}, 20'h00100, 2, 0, "outer invalid");
    walk({10'd5, 10'd9, 12'h456}, 20'h00100, 1, 0, "inner invalid");
    walk({10'd1023, 10'd1023, 12'hABC}, 20'h00100, 2, 0, "R11 junk low bits");
    walk({10'd0, 10'd0, 12'h010}, 20'h00100, 1, 1, "zero index busy request");

    // R10: stray read data while idle
    @(negedge clk);
    stray_req = 1;
    repeat (3) begin
      @(negedge clk);
      chk(resp_valid == 1'b0, "R10 no response from stray data", 32'(resp_valid), 32'd0);
      chk(mem_rd_en == 1'b0, "R10 no read from stray data", 32'(mem_rd_en), 32'd0);
      chk(req_ready == 1'b1, "R10 still idle", 32'(req_ready), 32'd1);
    end
    walk({10'd5, 10'd7, 12'h000}, 20'h00100, 2, 1, "after stray");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule